// File: doc/BRIEF.md
# Adaptive Delta Modulation Codec Core

This block holds the digital loops of an adaptive delta modulator for video, together with the matching receive loop. On each accepted sample the transmit side takes a single comparator decision. The decision is 1 when the analog input lies above the current estimate and 0 otherwise, and it is the transmitted bit. From that bit the transmit side adapts a step size, moves a leaky running estimate up or down by that step, and presents the estimate as a word for an external DAC. The receive side runs the same step and estimate loop on the received bit stream. With an error-free channel its estimate is the reconstructed signal and equals the transmit estimate.

Both values are counted in quarter units of the smallest step. The estimate is an 8-bit two's complement word that spans -32 to +31.75 smallest steps. The step is a 7-bit unsigned word that spans 1 to 16 smallest steps, which is 4 to 64 quarter units. The leak subtracts the estimate shifted right arithmetically by `LEAK_N` places. Because that shift truncates, a small offset stops decaying at a residual floor instead of vanishing. A line-sync pulse arms a clear, and each side clears its estimate and step on its first positive bit that follows. Because both sides see the same bits, they clear on the same sample.

Each side accepts one sample per cycle when its valid input is high and never applies back-pressure, so there is no ready signal. With valid low the loop holds its state, and the producer may stall for any number of cycles.

Top module: `adm_codec`

## Requirements
- R1: After reset, both estimates and both steps read 0, `bit_valid` is 0 and `bit_out` is 0.
- R2: One cycle after a cycle with `enc_valid` high, `bit_valid` is 1 and `bit_out` equals the `cmp_bit` of that cycle. After a cycle with `enc_valid` low, `bit_valid` is 0.
- R3: On an accepted sample that is not a clear, the new step is the old step plus half the old step (truncated) when the bit equals the previous accepted bit. Otherwise it is half the old step (truncated). The result is then clamped to the range 4 to 64. The previous bit is 0 after reset.
- R4: On an accepted sample that is not a clear, the new estimate is the old estimate minus (old estimate arithmetically shifted right by `LEAK_N`, default 6). The new step is then added when the bit is 1 and subtracted when it is 0.
- R5: The estimate saturates at +127 and -128 quarter units and never wraps.
- R6: A cycle with the side's sync input high arms a clear. The first later accepted sample with bit 1 sets estimate and step to 0 and disarms. Accepted samples with bit 0 and cycles with valid low do not clear. Sync in the same cycle as a clearing sample leaves the side armed.
- R7: While a side's valid input is low, its estimate and step do not change.
- R8: When the receive side gets the same valid, bit and sync as the transmit side in the same cycles, its estimate and step equal the transmit ones on every cycle.
- R9: After one inverted received bit, the receive estimate and step differ from the transmit ones on the next cycle. On a constant input held by the closed loop, the steps agree again within 19 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_valid | input | 1 | Transmit sample strobe |
| cmp_bit | input | 1 | Comparator decision, 1 when input is above estimate |
| enc_sync | input | 1 | Transmit line-sync pulse, arms a clear |
| bit_out | output | 1 | Transmitted bit, registered |
| bit_valid | output | 1 | Marks a fresh `bit_out` |
| enc_est | output | 8 | Transmit estimate for the DAC, quarter units, two's complement |
| enc_step | output | 7 | Transmit step, quarter units |
| dec_valid | input | 1 | Receive sample strobe |
| rx_bit | input | 1 | Received bit |
| dec_sync | input | 1 | Receive line-sync pulse, arms a clear |
| dec_est | output | 8 | Receive estimate (reconstructed signal) |
| dec_step | output | 7 | Receive step, quarter units |

## Verification
The assertions check on every cycle that the output bit and its valid flag follow the sample strobe one cycle later, that each side freezes while its strobe is low, and that the step is either cleared or inside its clamp range. The exact step and estimate arithmetic is shown only by the bench scenarios, because it depends on a reference model that runs on the stimulus. The same holds for saturation, the leak, the armed clear on the first positive bit, lock-step agreement of the two sides, and recovery of the step after a corrupted bit.

// File: rtl/adm_pkg.sv
package adm_pkg;
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_GROW   = 2'd1,
    OP_SHRINK = 2'd2,
    OP_CLEAR  = 2'd3
  } step_op_e;
endpackage

// File: rtl/adm_step.sv
module adm_step
  import adm_pkg::*;
#(
  parameter int STEP_W   = 7,
  parameter int STEP_MIN = 4,
  parameter int STEP_MAX = 64
) (
  input  step_op_e            op,
  input  logic [STEP_W-1:0]   cur,
  output logic [STEP_W-1:0]   nxt
);
  localparam int WW = STEP_W + 1;

  logic [WW-1:0] wide_cur;
  logic [WW-1:0] grown;
  logic [WW-1:0] shrunk;

  assign wide_cur = {1'b0, cur};
  assign grown    = wide_cur + (wide_cur >> 1);
  assign shrunk   = wide_cur >> 1;

  function automatic logic [STEP_W-1:0] clamp_step(input logic [WW-1:0] v);
    if (v < WW'(STEP_MIN))      return STEP_W'(STEP_MIN);
    else if (v > WW'(STEP_MAX)) return STEP_W'(STEP_MAX);
    else                        return v[STEP_W-1:0];
  endfunction

  always_comb begin
    unique case (op)
      OP_GROW:   nxt = clamp_step(grown);
      OP_SHRINK: nxt = clamp_step(shrunk);
      OP_CLEAR:  nxt = '0;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/adm_leak.sv
module adm_leak #(
  parameter int EST_W  = 8,
  parameter int STEP_W = 7,
  parameter int LEAK_N = 6
) (
  input  logic signed [EST_W-1:0] est,
  input  logic [STEP_W-1:0]       step,
  input  logic                    up,
  input  logic                    clear,
  output logic signed [EST_W-1:0] nxt
);
  localparam int WW = EST_W + 2;
  localparam int HI = (1 << (EST_W - 1)) - 1;
  localparam int LO = -(1 << (EST_W - 1));

  logic signed [WW-1:0] ext_est;
  logic signed [WW-1:0] ext_leak;
  logic signed [WW-1:0] ext_step;
  logic signed [WW-1:0] sum;

  assign ext_est  = {{2{est[EST_W-1]}}, est};
  assign ext_leak = ext_est >>> LEAK_N;
  assign ext_step = {{(WW-STEP_W){1'b0}}, step};
  assign sum      = up ? (ext_est - ext_leak + ext_step)
                       : (ext_est - ext_leak - ext_step);

  always_comb begin
    if (clear)                 nxt = '0;
    else if (sum > WW'(HI))    nxt = EST_W'(HI);
    else if (sum < WW'(LO))    nxt = EST_W'(LO);
    else                       nxt = sum[EST_W-1:0];
  end
endmodule

// File: rtl/adm_track.sv
module adm_track
  import adm_pkg::*;
#(
  parameter int EST_W    = 8,
  parameter int STEP_W   = 7,
  parameter int STEP_MIN = 4,
  parameter int STEP_MAX = 64,
  parameter int LEAK_N   = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  logic                    bit_in,
  input  logic                    sync,
  output logic [EST_W-1:0]        est,
  output logic [STEP_W-1:0]       step
);
  logic signed [EST_W-1:0] est_q, est_nxt;
  logic [STEP_W-1:0]       step_q, step_nxt;
  logic                    prev_q;
  logic                    armed_q;
  logic                    fire;
  step_op_e                op;

  assign fire = valid & bit_in & armed_q;

  always_comb begin
    if (fire)                  op = OP_CLEAR;
    else if (!valid)           op = OP_HOLD;
    else if (bit_in == prev_q) op = OP_GROW;
    else                       op = OP_SHRINK;
  end

  adm_step #(
    .STEP_W  (STEP_W),
    .STEP_MIN(STEP_MIN),
    .STEP_MAX(STEP_MAX)
  ) u_step (
    .op (op),
    .cur(step_q),
    .nxt(step_nxt)
  );

  adm_leak #(
    .EST_W (EST_W),
    .STEP_W(STEP_W),
    .LEAK_N(LEAK_N)
  ) u_leak (
    .est  (est_q),
    .step (step_nxt),
    .up   (bit_in),
    .clear(fire),
    .nxt  (est_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      est_q  <= '0;
      step_q <= '0;
      prev_q <= 1'b0;
    end else if (valid) begin
      est_q  <= est_nxt;
      step_q <= step_nxt;
      prev_q <= bit_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (sync)   armed_q <= 1'b1;
    else if (fire)   armed_q <= 1'b0;
  end

  assign est  = est_q;
  assign step = step_q;
endmodule

// File: rtl/adm_codec.sv
module adm_codec #(
  parameter int EST_W    = 8,
  parameter int STEP_W   = 7,
  parameter int STEP_MIN = 4,
  parameter int STEP_MAX = 64,
  parameter int LEAK_N   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_valid,
  input  logic              cmp_bit,
  input  logic              enc_sync,
  output logic              bit_out,
  output logic              bit_valid,
  output logic [EST_W-1:0]  enc_est,
  output logic [STEP_W-1:0] enc_step,
  input  logic              dec_valid,
  input  logic              rx_bit,
  input  logic              dec_sync,
  output logic [EST_W-1:0]  dec_est,
  output logic [STEP_W-1:0] dec_step
);
  localparam int SIDES = 2;

  logic [SIDES-1:0]  s_valid, s_bit, s_sync;
  logic [EST_W-1:0]  s_est  [SIDES];
  logic [STEP_W-1:0] s_step [SIDES];

  assign s_valid = {dec_valid, enc_valid};
  assign s_bit   = {rx_bit,    cmp_bit};
  assign s_sync  = {dec_sync,  enc_sync};

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    adm_track #(
      .EST_W   (EST_W),
      .STEP_W  (STEP_W),
      .STEP_MIN(STEP_MIN),
      .STEP_MAX(STEP_MAX),
      .LEAK_N  (LEAK_N)
    ) u_track (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (s_valid[g]),
      .bit_in(s_bit[g]),
      .sync  (s_sync[g]),
      .est   (s_est[g]),
      .step  (s_step[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      bit_valid <= enc_valid;
      if (enc_valid) bit_out <= cmp_bit;
    end
  end

  assign enc_est  = s_est[0];
  assign enc_step = s_step[0];
  assign dec_est  = s_est[1];
  assign dec_step = s_step[1];
endmodule

// File: rtl/adm_codec_chk.sv
module adm_codec_chk #(
  parameter int EST_W    = 8,
  parameter int STEP_W   = 7,
  parameter int STEP_MIN = 4,
  parameter int STEP_MAX = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enc_valid,
  input logic              cmp_bit,
  input logic              bit_out,
  input logic              bit_valid,
  input logic [EST_W-1:0]  enc_est,
  input logic [STEP_W-1:0] enc_step,
  input logic              dec_valid,
  input logic [EST_W-1:0]  dec_est,
  input logic [STEP_W-1:0] dec_step
);
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> bit_valid);

  a_r2_bit_copy: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |=> (bit_out == $past(cmp_bit)));

  a_r7_enc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid |=> ($stable(enc_est) && $stable(enc_step) && !bit_valid));

  a_r7_dec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> ($stable(dec_est) && $stable(dec_step)));

  a_r3_enc_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_step == '0) || ((int'(enc_step) >= STEP_MIN) && (int'(enc_step) <= STEP_MAX)));

  a_r3_dec_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_step == '0) || ((int'(dec_step) >= STEP_MIN) && (int'(dec_step) <= STEP_MAX)));
endmodule

bind adm_codec adm_codec_chk #(
  .EST_W   (EST_W),
  .STEP_W  (STEP_W),
  .STEP_MIN(STEP_MIN),
  .STEP_MAX(STEP_MAX)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enc_valid(enc_valid),
  .cmp_bit  (cmp_bit),
  .bit_out  (bit_out),
  .bit_valid(bit_valid),
  .enc_est  (enc_est),
  .enc_step (enc_step),
  .dec_valid(dec_valid),
  .dec_est  (dec_est),
  .dec_step (dec_step)
);

// File: tb/adm_codec_bench.sv
module adm_codec_bench;
  localparam int LEAK_N = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_valid = 1'b0, cmp_bit = 1'b0, enc_sync = 1'b0;
  logic       dec_valid = 1'b0, rx_bit = 1'b0, dec_sync = 1'b0;
  logic       bit_out, bit_valid;
  logic [7:0] enc_est, dec_est;
  logic [6:0] enc_step, dec_step;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int m_est, m_step, m_prev, m_armed;
  bit dec_aligned;

  always #2.5 clk = ~clk;

  adm_codec u_adm_codec (
    .clk(clk), .rst_n(rst_n),
    .enc_valid(enc_valid), .cmp_bit(cmp_bit), .enc_sync(enc_sync),
    .bit_out(bit_out), .bit_valid(bit_valid),
    .enc_est(enc_est), .enc_step(enc_step),
    .dec_valid(dec_valid), .rx_bit(rx_bit), .dec_sync(dec_sync),
    .dec_est(dec_est), .dec_step(dec_step)
  );

  function automatic int sest(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_ne(input string tag, input int act, input int other);
    checks++;
    if (act == other) begin
      failures++;
      $display("FAIL %s actual=%0d expected anything but %0d", tag, act, other);
    end
  endtask

  task automatic model_step(input int b, input int sy);
    int fire, ns, ne;
    fire = m_armed & b;
    if (fire != 0) begin
      m_est = 0; m_step = 0;
    end else begin
      ns = (b == m_prev) ? m_step + m_step / 2 : m_step / 2;
      if (ns < 4) ns = 4;
      if (ns > 64) ns = 64;
      ne = m_est - (m_est >>> LEAK_N) + ((b != 0) ? ns : -ns);
      if (ne > 127) ne = 127;
      if (ne < -128) ne = -128;
      m_est = ne; m_step = ns;
    end
    m_prev = b;
    if (sy != 0) m_armed = 1;
    else if (fire != 0) m_armed = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    enc_valid = 0; dec_valid = 0; enc_sync = 0; dec_sync = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_est = 0; m_step = 0; m_prev = 0; m_armed = 0;
    dec_aligned = 1;
  endtask

  // One accepted sample on both sides; starts and ends at a falling edge.
  task automatic sample(input bit b, input bit sy, input bit flip);
    enc_valid = 1; cmp_bit = b; enc_sync = sy;
    dec_valid = 1; rx_bit = b ^ flip; dec_sync = sy;
    @(negedge clk);
    model_step(int'(b), int'(sy));
    if (flip) dec_aligned = 0;
    check_eq("R4 estimate", sest(enc_est), m_est);
    check_eq("R3 step", int'(enc_step), m_step);
    check_eq("R2 bit_out", int'(bit_out), int'(b));
    check_eq("R2 bit_valid", int'(bit_valid), 1);
    if (dec_aligned) begin
      check_eq("R8 dec estimate", sest(dec_est), sest(enc_est));
      check_eq("R8 dec step", int'(dec_step), int'(enc_step));
    end
    enc_valid = 0; dec_valid = 0; enc_sync = 0; dec_sync = 0;
  endtask

  task automatic track(input int target, input bit flip);
    sample(target > sest(enc_est), 1'b0, flip);
  endtask

  task automatic t_reset();
    do_reset();
    check_eq("R1 enc_est", sest(enc_est), 0);
    check_eq("R1 enc_step", int'(enc_step), 0);
    check_eq("R1 dec_est", sest(dec_est), 0);
    check_eq("R1 dec_step", int'(dec_step), 0);
    check_eq("R1 bit_valid", int'(bit_valid), 0);
    check_eq("R1 bit_out", int'(bit_out), 0);
  endtask

  task automatic t_step_chain();
    int exp_step[6] = '{4, 6, 9, 13, 19, 9};
    int exp_est[6]  = '{4, 10, 19, 32, 51, 42};
    bit bits[6]     = '{1, 1, 1, 1, 1, 0};
    do_reset();
    for (int i = 0; i < 6; i++) begin
      sample(bits[i], 1'b0, 1'b0);
      check_eq("R3 step chain", int'(enc_step), exp_step[i]);
      check_eq("R4 estimate chain", sest(enc_est), exp_est[i]);
    end
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 14; i++) sample(1'b1, 1'b0, 1'b0);
    check_eq("R5 top clip", sest(enc_est), 127);
    check_eq("R3 step at max", int'(enc_step), 64);
    sample(1'b0, 1'b0, 1'b0);
    check_eq("R4 leak from 127", sest(enc_est), 94);
    for (int i = 0; i < 20; i++) sample(1'b0, 1'b0, 1'b0);
    check_eq("R5 bottom clip", sest(enc_est), -128);
  endtask

  task automatic t_hold();
    int e, s;
    do_reset();
    for (int i = 0; i < 5; i++) sample(1'b1, 1'b0, 1'b0);
    e = sest(enc_est); s = int'(enc_step);
    for (int i = 0; i < 3; i++) begin
      cmp_bit = i[0]; rx_bit = ~i[0];
      @(negedge clk);
      check_eq("R7 enc est held", sest(enc_est), e);
      check_eq("R7 enc step held", int'(enc_step), s);
      check_eq("R7 dec est held", sest(dec_est), e);
      check_eq("R2 valid low", int'(bit_valid), 0);
    end
  endtask

  task automatic t_sync();
    do_reset();
    for (int i = 0; i < 4; i++) sample(1'b1, 1'b0, 1'b0);
    sample(1'b0, 1'b1, 1'b0);
    check_ne("R6 sync sample does not clear", int'(enc_step), 0);
    sample(1'b0, 1'b0, 1'b0);
    sample(1'b0, 1'b0, 1'b0);
    check_ne("R6 negative bit keeps state", int'(enc_step), 0);
    cmp_bit = 1; rx_bit = 1;
    @(negedge clk);
    check_ne("R6 idle positive bit keeps state", int'(enc_step), 0);
    sample(1'b1, 1'b0, 1'b0);
    check_eq("R6 clear estimate", sest(enc_est), 0);
    check_eq("R6 clear step", int'(enc_step), 0);
    check_eq("R6 dec clear", sest(dec_est), 0);
    sample(1'b1, 1'b0, 1'b0);
    check_eq("R6 disarmed after clear", int'(enc_step), 4);
    check_eq("R6 estimate after clear", sest(enc_est), 4);
    // sync coinciding with a clearing sample leaves the side armed
    sample(1'b0, 1'b1, 1'b0);
    sample(1'b1, 1'b1, 1'b0);
    check_eq("R6 clear with sync", int'(enc_step), 0);
    sample(1'b1, 1'b0, 1'b0);
    check_eq("R6 re-armed clear", int'(enc_step), 0);
  endtask

  task automatic t_loopback();
    do_reset();
    for (int i = 0; i < 30; i++) track(60, 1'b0);
    for (int i = 0; i < 30; i++) track(-90, 1'b0);
    for (int i = 0; i < 20; i++) track(8, 1'b0);
    check_eq("R8 lock-step after pattern", sest(dec_est), sest(enc_est));
  endtask

  task automatic t_flip();
    do_reset();
    for (int i = 0; i < 40; i++) track(40, 1'b0);
    track(40, 1'b1);
    check_ne("R9 step disturbed", int'(dec_step), int'(enc_step));
    check_ne("R9 estimate shifted", sest(dec_est), sest(enc_est));
    for (int i = 0; i < 19; i++) track(40, 1'b0);
    check_eq("R9 step recovered", int'(dec_step), int'(enc_step));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_step_chain();
    t_saturate();
    t_hold();
    t_sync();
    t_loopback();
    t_flip();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule